// File: doc/BRIEF.md
# Tightly-Coupled Memory Address Router

This block sits between a processor core and its local memories. Each cycle the core may present one request: an instruction fetch or a data read or write. The router decides in that same cycle whether the request is served by the instruction-side local RAM, the data-side local RAM, a small control register, or the external bus. Local RAM reads and control-register reads return data one cycle later. External requests are handed off to the bus in a single cycle, and the core collects the bus answer itself.

Two configuration flags control the routing. The first enables the local-RAM decode. The second selects a high exception-vector base. Both flags take their values from strap pins at every reset, and software can overwrite them later through the control register. The local RAMs occupy only the bottom 128 MB of the address space. The lower 64 MB of that window is the instruction RAM and the upper 64 MB is the data RAM. Each RAM repeats (aliases) across its half of the window. A fetch that lands in the data half is passed to the external bus at the same address, because the data RAM never answers fetches.

Top module: `tcm_router`

## Requirements
- R1: While req_valid is high, exactly one of sel_itcm, sel_dtcm, sel_ext and sel_ctrl is high in that same cycle. While req_valid is low, all four are low.
- R2: With the enable flag set, a fetch or data access to 0x00000000–0x03FFFFFF goes to the instruction RAM. The word index is address bits [IAW+1:2], where IAW = log2(ITCM_WORDS), so addresses that differ by ITCM_WORDS*4 reach the same word. A data write there is returned by a later read or fetch of that word.
- R3: With the enable flag set, a data access to 0x04000000–0x07FFFFFF goes to the data RAM. The word index is address bits [DAW+1:2], where DAW = log2(DTCM_WORDS), so addresses that differ by DTCM_WORDS*4 reach the same word.
- R4: A fetch to 0x04000000–0x07FFFFFF is never sent to the data RAM. It goes to the external bus, and ext_addr equals the request address.
- R5: Any access at or above 0x08000000 goes to the external bus, except a data access to CTRL_ADDR.
- R6: With the enable flag clear, every access except a data access to CTRL_ADDR goes to the external bus.
- R7: ext_req is high only in a cycle where sel_ext is high. In that cycle ext_addr and ext_wdata carry the request's address and write data, and ext_write is high for a data write and low for a fetch or read.
- R8: A read or fetch served by either local RAM or by the control register raises rsp_valid exactly one cycle later, with the read word on rsp_rdata. Writes, external requests and idle cycles leave rsp_valid low one cycle later.
- R9: While rst_n is low, rsp_valid is low. From the third rising edge after rst_n is released, the enable flag equals strap_tcm_en and the high-vector flag equals strap_hivec. Later edges keep those values until software writes the control register.
- R10: The control register sits at CTRL_ADDR (default 0xF0000000). A data write loads bit 0 into the enable flag and bit 1 into the high-vector flag, and ignores all other bits. The new values govern the very next request. A data read returns the enable flag in bit 0, the high-vector flag in bit 1, and zero elsewhere. A fetch from CTRL_ADDR goes to the external bus.
- R11: vec_base is 0xFFFF0000 while the high-vector flag is set and 0x00000000 while it is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_tcm_en | input | 1 | Reset value of the local-RAM enable flag |
| strap_hivec | input | 1 | Reset value of the high-vector flag |
| req_valid | input | 1 | Request present this cycle |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_write | input | 1 | Request is a data write (ignored for fetches) |
| req_addr | input | 32 | Byte address |
| req_wdata | input | DW | Write data |
| sel_itcm | output | 1 | Request routed to the instruction RAM |
| sel_dtcm | output | 1 | Request routed to the data RAM |
| sel_ext | output | 1 | Request routed to the external bus |
| sel_ctrl | output | 1 | Request routed to the control register |
| rsp_valid | output | 1 | Local read data valid (one cycle after the request) |
| rsp_rdata | output | DW | Local read data |
| ext_req | output | 1 | External bus request strobe |
| ext_write | output | 1 | External request is a write |
| ext_addr | output | 32 | External request address, unchanged |
| ext_wdata | output | DW | External write data |
| vec_base | output | 32 | Exception vector base |

## Verification
Two things share every cycle. The registered read answer for the previous request leaves on rsp_valid/rsp_rdata while the present request is decoded against the flags as they stand. The bench provokes this overlap with unbroken back-to-back streams: a RAM read followed at once by a control-register write that disables the RAMs, then a request to the same address, and a randomized burst with no idle cycles between requests. A behavioural model compares the selects, the bus handoff, the vector base and the one-cycle-late answer on every cycle. This shows that the late answer comes from the earlier request, and that the flags in force are those written on the previous edge.

// File: rtl/tcm_router_pkg.sv
package tcm_router_pkg;

  // Address layout of the local-memory window.
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned WIN_LSB    = 27;   // window = addr[31:27] == 0 (128 MB)
  localparam int unsigned REGION_BIT = 26;   // 0: instruction half, 1: data half
  localparam logic [31:0] HIGH_VEC_BASE = 32'hFFFF_0000;

  // Routing targets; the numeric order is the index of the select vector.
  typedef enum logic [1:0] {
    TGT_ITCM = 2'd0,
    TGT_DTCM = 2'd1,
    TGT_EXT  = 2'd2,
    TGT_CTRL = 2'd3
  } tgt_e;

  localparam int unsigned NUM_TGT = 4;

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WIN_LSB] == '0;
  endfunction

endpackage

// File: rtl/tcm_rst_sync.sv
module tcm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tcm_cfg_regs.sv
module tcm_cfg_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_tcm_en,
  input  logic       strap_hivec,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output logic       tcm_en,
  output logic       hivec
);

  logic boot_q, boot_d;
  logic en_q, en_d;
  logic hv_q, hv_d;

  // The first clock after reset release copies the straps; later clocks
  // accept software writes.
  always_comb begin
    boot_d = 1'b1;
    en_d   = en_q;
    hv_d   = hv_q;
    if (!boot_q) begin
      en_d = strap_tcm_en;
      hv_d = strap_hivec;
    end else if (wr_en) begin
      en_d = wr_data[0];
      hv_d = wr_data[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b0;
      en_q   <= 1'b0;
      hv_q   <= 1'b0;
    end else begin
      boot_q <= boot_d;
      en_q   <= en_d;
      hv_q   <= hv_d;
    end
  end

  assign tcm_en = en_q;
  assign hivec  = hv_q;

  AST_STRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_q) |-> (en_q == $past(strap_tcm_en)) && (hv_q == $past(strap_hivec))); // R9

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_q && wr_en) |=> (en_q == $past(wr_data[0])) && (hv_q == $past(wr_data[1]))); // R10

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_q && !wr_en) |=> $stable(en_q) && $stable(hv_q)); // R10

endmodule

// File: rtl/tcm_addr_decode.sv
module tcm_addr_decode
  import tcm_router_pkg::*;
#(
  parameter logic [31:0] CTRL_ADDR = 32'hF000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tcm_en_i,
  output tgt_e              tgt_o
);

  logic is_ctrl;
  logic in_win;

  assign is_ctrl = !fetch_i && (addr_i == CTRL_ADDR);
  assign in_win  = in_window(addr_i);

  always_comb begin
    tgt_o = TGT_EXT;
    if (is_ctrl) begin
      tgt_o = TGT_CTRL;
    end else if (tcm_en_i && in_win) begin
      if (!addr_i[REGION_BIT]) tgt_o = TGT_ITCM;
      else if (!fetch_i)       tgt_o = TGT_DTCM;
      else                     tgt_o = TGT_EXT;   // fetch never served by data RAM
    end
  end

  AST_FETCH_NO_DTCM: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && fetch_i) |-> (tgt_o != TGT_DTCM)); // R4

  AST_OUTSIDE_WIN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (addr_i[ADDR_W-1:WIN_LSB] != '0) && (fetch_i || addr_i != CTRL_ADDR))
      |-> (tgt_o == TGT_EXT)); // R5

  AST_DISABLED_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !tcm_en_i && (fetch_i || addr_i != CTRL_ADDR)) |-> (tgt_o == TGT_EXT)); // R6

endmodule

// File: rtl/tcm_sram.sv
module tcm_sram #(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) mem[idx] <= wdata;
      else    rdata_q  <= mem[idx];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/tcm_router.sv
module tcm_router
  import tcm_router_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned ITCM_WORDS = 1024,
  parameter int unsigned DTCM_WORDS = 1024,
  parameter logic [31:0] CTRL_ADDR  = 32'hF000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_tcm_en,
  input  logic          strap_hivec,
  input  logic          req_valid,
  input  logic          req_fetch,
  input  logic          req_write,
  input  logic [31:0]   req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          sel_itcm,
  output logic          sel_dtcm,
  output logic          sel_ext,
  output logic          sel_ctrl,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          ext_req,
  output logic          ext_write,
  output logic [31:0]   ext_addr,
  output logic [DW-1:0] ext_wdata,
  output logic [31:0]   vec_base
);

  localparam int unsigned IAW = $clog2(ITCM_WORDS);
  localparam int unsigned DAW = $clog2(DTCM_WORDS);

  logic               rst_i_n;
  logic               tcm_en;
  logic               hivec;
  tgt_e               tgt;
  logic [NUM_TGT-1:0] sel;
  logic               wr_eff;
  logic               rd_local;
  logic [DW-1:0]      itcm_rdata;
  logic [DW-1:0]      dtcm_rdata;

  // Response pipeline registers
  logic       rsp_valid_q, rsp_valid_d;
  tgt_e       rsp_src_q, rsp_src_d;
  logic [1:0] ctrl_rd_q, ctrl_rd_d;
  logic       ctrl_rd_ce;

  tcm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign wr_eff = req_write && !req_fetch;

  tcm_cfg_regs u_cfg (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .strap_tcm_en (strap_tcm_en),
    .strap_hivec  (strap_hivec),
    .wr_en        (sel[TGT_CTRL] && wr_eff),
    .wr_data      (req_wdata[1:0]),
    .tcm_en       (tcm_en),
    .hivec        (hivec)
  );

  tcm_addr_decode #(.CTRL_ADDR(CTRL_ADDR)) u_decode (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .valid_i  (req_valid),
    .fetch_i  (req_fetch),
    .addr_i   (req_addr),
    .tcm_en_i (tcm_en),
    .tgt_o    (tgt)
  );

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
    assign sel[g] = req_valid && (tgt == tgt_e'(g));
  end

  assign sel_itcm = sel[TGT_ITCM];
  assign sel_dtcm = sel[TGT_DTCM];
  assign sel_ext  = sel[TGT_EXT];
  assign sel_ctrl = sel[TGT_CTRL];

  tcm_sram #(.WORDS(ITCM_WORDS), .DW(DW)) u_itcm (
    .clk   (clk),
    .ce    (sel[TGT_ITCM]),
    .we    (wr_eff),
    .idx   (req_addr[IAW+1:2]),
    .wdata (req_wdata),
    .rdata (itcm_rdata)
  );

  tcm_sram #(.WORDS(DTCM_WORDS), .DW(DW)) u_dtcm (
    .clk   (clk),
    .ce    (sel[TGT_DTCM]),
    .we    (wr_eff),
    .idx   (req_addr[DAW+1:2]),
    .wdata (req_wdata),
    .rdata (dtcm_rdata)
  );

  // Local read answers arrive one cycle after the request.
  assign rd_local   = !wr_eff && (sel[TGT_ITCM] || sel[TGT_DTCM] || sel[TGT_CTRL]);
  assign ctrl_rd_ce = sel[TGT_CTRL] && !wr_eff;

  always_comb begin
    rsp_valid_d = rd_local;
    rsp_src_d   = rd_local ? tgt : rsp_src_q;
    ctrl_rd_d   = ctrl_rd_ce ? {hivec, tcm_en} : ctrl_rd_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_valid_q <= 1'b0;
      rsp_src_q   <= TGT_EXT;
      ctrl_rd_q   <= 2'b00;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_src_q   <= rsp_src_d;
      ctrl_rd_q   <= ctrl_rd_d;
    end
  end

  always_comb begin
    unique case (rsp_src_q)
      TGT_ITCM: rsp_rdata = itcm_rdata;
      TGT_DTCM: rsp_rdata = dtcm_rdata;
      TGT_CTRL: rsp_rdata = {{(DW-2){1'b0}}, ctrl_rd_q};
      default:  rsp_rdata = '0;
    endcase
  end

  assign rsp_valid = rsp_valid_q;

  // Single-cycle handoff to the external bus.
  assign ext_req   = sel[TGT_EXT];
  assign ext_write = wr_eff;
  assign ext_addr  = req_addr;
  assign ext_wdata = req_wdata;

  assign vec_base = hivec ? HIGH_VEC_BASE : 32'h0000_0000;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |-> $onehot({sel_itcm, sel_dtcm, sel_ext, sel_ctrl})); // R1

  AST_IDLE_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_i_n)
    !req_valid |-> ({sel_itcm, sel_dtcm, sel_ext, sel_ctrl} == 4'b0000)); // R1

  AST_LOCAL_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && !wr_eff && !sel_ext) |=> rsp_valid); // R8

  AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!req_valid || wr_eff || sel_ext) |=> !rsp_valid); // R8

  AST_EXT_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_i_n)
    ext_req |-> (req_valid && !sel_itcm && !sel_dtcm && !sel_ctrl)); // R7

endmodule

// File: tb/tcm_router_test.sv
`timescale 1ns/1ps
module tcm_router_test;

  localparam int unsigned IWORDS = 1024;
  localparam int unsigned DWORDS = 1024;
  localparam logic [31:0] CTRL   = 32'hF000_0000;

  logic        clk;
  logic        rst_n;
  logic        strap_tcm_en, strap_hivec;
  logic        req_valid, req_fetch, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        sel_itcm, sel_dtcm, sel_ext, sel_ctrl;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        ext_req, ext_write;
  logic [31:0] ext_addr, ext_wdata, vec_base;

  tcm_router #(.DW(32), .ITCM_WORDS(IWORDS), .DTCM_WORDS(DWORDS), .CTRL_ADDR(CTRL)) uut (
    .clk(clk), .rst_n(rst_n), .strap_tcm_en(strap_tcm_en), .strap_hivec(strap_hivec),
    .req_valid(req_valid), .req_fetch(req_fetch), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .sel_itcm(sel_itcm), .sel_dtcm(sel_dtcm), .sel_ext(sel_ext), .sel_ctrl(sel_ctrl),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ext_req(ext_req), .ext_write(ext_write), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
    .vec_base(vec_base)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // Behavioural model state
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          m_en, m_hv;
  logic [31:0] imem [int];
  logic [31:0] dmem [int];
  bit          pend;
  bit          pend_known;
  logic [31:0] pend_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // 0 ITCM, 1 DTCM, 2 external, 3 control register
  function automatic int exp_tgt(input bit f, input logic [31:0] a);
    if (!f && a == CTRL)                return 3;
    if (!m_en || a >= 32'h0800_0000)    return 2;
    if (a < 32'h0400_0000)              return 0;
    if (f)                              return 2;
    return 1;
  endfunction

  // Drive one request just after a falling edge, check, advance the model.
  task automatic step(input bit v, input bit f, input bit w,
                      input logic [31:0] a, input logic [31:0] d, input string tag);
    int          t;
    int          idx;
    bit          wr;
    logic [3:0]  exp_sel;
    req_valid = v; req_fetch = f; req_write = w; req_addr = a; req_wdata = d;
    #1;
    chk("R8 rsp_valid", {31'b0, rsp_valid}, {31'b0, pend});
    if (pend && pend_known) chk("R8 rsp_rdata", rsp_rdata, pend_data);
    chk("R11 vec_base", vec_base, m_hv ? 32'hFFFF_0000 : 32'h0);
    t  = v ? exp_tgt(f, a) : -1;
    wr = w && !f;
    case (t)
      0: exp_sel = 4'b1000;
      1: exp_sel = 4'b0100;
      2: exp_sel = 4'b0010;
      3: exp_sel = 4'b0001;
      default: exp_sel = 4'b0000;
    endcase
    chk({tag, " R1 selects"}, {28'b0, sel_itcm, sel_dtcm, sel_ext, sel_ctrl}, {28'b0, exp_sel});
    chk("R7 ext_req", {31'b0, ext_req}, {31'b0, (t == 2)});
    if (t == 2) begin
      chk({tag, " R7 ext_addr"}, ext_addr, a);
      chk("R7 ext_write", {31'b0, ext_write}, {31'b0, wr});
      if (wr) chk("R7 ext_wdata", ext_wdata, d);
    end
    pend = 1'b0;
    case (t)
      0: begin
        idx = int'((a >> 2) % IWORDS);
        if (wr) imem[idx] = d;
        else begin
          pend = 1'b1; pend_known = imem.exists(idx);
          if (pend_known) pend_data = imem[idx];
        end
      end
      1: begin
        idx = int'((a >> 2) % DWORDS);
        if (wr) dmem[idx] = d;
        else begin
          pend = 1'b1; pend_known = dmem.exists(idx);
          if (pend_known) pend_data = dmem[idx];
        end
      end
      3: begin
        if (wr) begin
          m_en = d[0]; m_hv = d[1];
        end else begin
          pend = 1'b1; pend_known = 1'b1;
          pend_data = {30'b0, m_hv, m_en};
        end
      end
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic do_reset(input bit en, input bit hv);
    rst_n = 1'b0; strap_tcm_en = en; strap_hivec = hv;
    req_valid = 1'b0; req_fetch = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    m_en = en; m_hv = hv; pend = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R9 rsp_valid in reset", {31'b0, rsp_valid}, 32'b0);
      chk("R9 ext_req in reset", {31'b0, ext_req}, 32'b0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] ad;
    @(negedge clk);
    do_reset(1'b1, 1'b0);

    step(0, 0, 0, 32'h0, 32'h0, "R1 idle");
    step(1, 0, 0, CTRL, 32'h0, "R9 strap read");            // expect 01
    step(1, 0, 1, 32'h0000_0010, 32'hA5A5_0001, "R2 itcm write");
    step(1, 0, 0, 32'h0000_0010, 32'h0, "R2 itcm read");
    step(1, 0, 0, 32'h0000_0010 + IWORDS*4, 32'h0, "R2 itcm alias");
    step(1, 1, 0, 32'h0000_0010, 32'h0, "R2 itcm fetch");
    step(1, 0, 1, 32'h0400_0020, 32'h5A5A_0002, "R3 dtcm write");
    step(1, 0, 0, 32'h0400_0020, 32'h0, "R3 dtcm read");
    step(1, 0, 0, 32'h0400_0020 + DWORDS*4, 32'h0, "R3 dtcm alias");
    step(1, 1, 0, 32'h0400_0020, 32'h0, "R4 fetch in data half");
    step(1, 1, 0, 32'h07FF_FFFC, 32'h0, "R4 fetch top of data half");
    step(1, 0, 0, 32'h0800_0000, 32'h0, "R5 above window");
    step(1, 0, 1, 32'h1234_5678, 32'hDEAD_BEEF, "R5 ext write");
    step(1, 1, 0, CTRL, 32'h0, "R10 fetch ctrl addr");
    step(1, 0, 0, 32'h0000_0010, 32'h0, "R8 read before ctrl write");
    step(1, 0, 1, CTRL, 32'hFFFF_FFFE, "R10 ctrl write disable+hivec");
    step(1, 0, 0, 32'h0000_0010, 32'h0, "R6 disabled itcm addr");
    step(1, 0, 1, 32'h0400_0020, 32'h0000_1111, "R6 disabled dtcm write");
    step(1, 0, 0, CTRL, 32'h0, "R10 ctrl readback");
    step(1, 0, 1, CTRL, 32'h0000_0001, "R10 ctrl enable");
    step(1, 0, 0, 32'h0400_0020, 32'h0, "R6 dtcm untouched while off");
    step(0, 0, 0, 32'h0, 32'h0, "R8 idle after read");

    do_reset(1'b0, 1'b1);
    step(1, 0, 0, CTRL, 32'h0, "R9 strap read 2");           // expect 10
    step(1, 0, 0, 32'h0000_0010, 32'h0, "R6 strap disabled");
    step(1, 0, 1, CTRL, 32'h0000_0003, "R10 enable keep hivec");
    step(1, 0, 0, 32'h0000_0010, 32'h0, "R2 itcm kept");

    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[1:0])
        2'd0: ad = {6'b0, lfsr[25:2], 2'b00};
        2'd1: ad = {5'b0, 1'b1, lfsr[25:2], 2'b00};
        2'd2: ad = {lfsr[31:4], 4'b0000} | 32'h0800_0000;
        default: ad = {5'b0, lfsr[8], 14'b0, lfsr[11:2], 2'b00};
      endcase
      step(1, lfsr[5], lfsr[6] & ~lfsr[5], ad, lfsr ^ 32'h1357_9BDF, "R1 burst");
    end
    step(0, 0, 0, 32'h0, 32'h0, "R8 drain");
    summary();
  end

endmodule